// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host port and an asynchronous fast page mode DRAM organised as 1M words of 36 bits. It takes one read or write request at a time over a valid/ready handshake. Each request becomes a sequence of row strobe, column strobe, write enable and output enable transitions on the memory pins. The 20-bit word address is split into a row half and a column half, and both halves go out over a shared 10-bit address bus.

After an access the row stays open. A later request to the same row runs only a column cycle. A request to another row first precharges, then opens the new row. The 36-bit word is made of four 9-bit lanes, and each lane has its own column strobe. A write therefore changes only the lanes the host enables. Writes are always early writes: W falls before the column strobe. An external refresh engine asks for the memory through a request/grant pair. The controller finishes the column cycle in progress, closes the page and then hands the memory over. A row-open watchdog closes the page before the longest allowed row-low time runs out.

Every analog timing limit is a parameter in nanoseconds. Each one is rounded up to whole cycles of the clock period parameter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row address is req_addr[19:10] and the column address is req_addr[9:0]. The row value is on dram_addr and stable when dram_ras_n falls. The column value is on dram_addr and stable when any dram_cas_n bit falls.
- R2: Lane i is data bits [9i+8:9i]. On a write, dram_cas_n[i] goes low only if req_lane[i] is 1, so disabled lanes keep their old content. On a read all four dram_cas_n bits go low together with dram_oe_n.
- R3: On a write, dram_we_n is already low in the cycle before the column strobe falls. dram_dq_oe is 1 and dram_oe_n stays 1 whenever dram_we_n is low.
- R4: With a row open, a request to that same row runs a column cycle only, with no new fall of dram_ras_n.
- R5: A request to another row raises dram_ras_n for at least the precharge time (2 cycles at defaults), then opens the new row.
- R6: dram_ras_n never stays low for more than the row-low limit (500 cycles at defaults). With no traffic, an open page is closed on its own before that limit.
- R7: A read returns the stored word on rsp_rdata with a one-cycle rsp_valid pulse. Responses come in request order. The word is sampled only after the column strobe, column address and row strobe access times have all passed.
- R8: Each row-low period lasts at least max(tRAS, tRC - tRP) (4 cycles at defaults). Each column strobe stays low for at least the column access time (2 cycles at defaults).
- R9: ref_gnt is asserted only when dram_ras_n and all dram_cas_n bits are high. A column cycle in progress completes first.
- R10: While ref_req or ref_gnt is high, req_ready is low and no host request is accepted. Host service resumes after ref_req drops.
- R11: After reset, dram_ras_n=1, dram_cas_n=4'hF, dram_we_n=1, dram_oe_n=1, dram_dq_oe=0, rsp_valid=0, ref_gnt=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper half |
| req_wdata | input | 36 | Write word, four 9-bit lanes |
| req_lane | input | 4 | Per-lane write enable |
| rsp_valid | output | 1 | Read word valid pulse |
| rsp_rdata | output | 36 | Read word |
| ref_req | input | 1 | Refresh engine wants the memory |
| ref_gnt | output | 1 | Memory handed to refresh engine |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 36 | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 36 | Data returned by the memory |

## Verification
The hardest cases to reach from the ports are the forced close at the row-low limit and a refresh request that arrives while a row is open. The host can trigger the first only by leaving a page open and sending nothing for hundreds of cycles. The bench does exactly that. It then confirms that the strobe went high before the limit and that the next access re-opens the row. For refresh, the bench raises ref_req right after a write and holds a competing read valid for the whole grant. That read must stay stalled until ref_req drops. It must then come back with the earlier data from a newly opened row.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_ACT,
      ST_CADDR,
      ST_COL,
      ST_OPEN,
      ST_PRE,
      ST_REF
   } fpm_state_e;

   function automatic int ns_to_cyc(input int ns, input int per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/fpm_ras_guard.sv
module fpm_ras_guard #(
   parameter int MAX_CYC = 500,
   parameter int MARGIN  = 6,
   parameter int W       = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ras_low,
   output logic [W-1:0] age,
   output logic         close_due
);

   localparam logic [W-1:0] CLOSE_AT = W'(MAX_CYC - MARGIN);
   localparam logic [W-1:0] LIMIT    = W'(MAX_CYC);

   if (MARGIN >= MAX_CYC) begin : g_bad_margin
      $error("row-low limit too short for one column cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else if (!ras_low)
         age <= '0;
      else if (age != '1)
         age <= age + 1'b1;
   end

   assign close_due = (age >= CLOSE_AT);

   // R6: a row-low period never reaches the limit
   a_r6_ras_low_window: assert property (@(posedge clk) disable iff (!rst_n)
      ras_low |-> (age < LIMIT));

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
   import fpm_pkg::*;
#(
   parameter int MA_W         = 10,
   parameter int ADDR_W       = 2 * MA_W,
   parameter int LANES        = 4,
   parameter int LANE_W       = 9,
   parameter int DATA_W       = LANES * LANE_W,
   parameter int CLK_NS       = 20,
   parameter int T_RP_NS      = 40,
   parameter int T_RAS_NS     = 60,
   parameter int T_RC_NS      = 110,
   parameter int T_CAS_NS     = 15,
   parameter int T_CP_NS      = 10,
   parameter int T_RAH_NS     = 10,
   parameter int T_CAH_NS     = 15,
   parameter int T_CAC_NS     = 15,
   parameter int T_AA_NS      = 30,
   parameter int T_RAC_NS     = 60,
   parameter int T_RASMAX_NS  = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_lane,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              ref_req,
   output logic              ref_gnt,
   output logic [MA_W-1:0]   dram_addr,
   output logic              dram_ras_n,
   output logic [LANES-1:0]  dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);

   // ---- cycle counts derived from nanosecond limits
   localparam int RP_CYC     = imax(1, ns_to_cyc(T_RP_NS, CLK_NS));
   localparam int RAS_CYC    = ns_to_cyc(T_RAS_NS, CLK_NS);
   localparam int RC_CYC     = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int HOLD_CYC   = imax(1, imax(RAS_CYC, RC_CYC - RP_CYC));
   localparam int RAH_CYC    = imax(1, ns_to_cyc(T_RAH_NS, CLK_NS));
   localparam int CADDR_CYC  = imax(1, ns_to_cyc(T_CP_NS, CLK_NS));
   localparam int COL_CYC    = imax(imax(1, ns_to_cyc(T_CAS_NS, CLK_NS)),
                                    imax(ns_to_cyc(T_CAH_NS, CLK_NS),
                                         imax(ns_to_cyc(T_CAC_NS, CLK_NS),
                                              ns_to_cyc(T_AA_NS, CLK_NS))));
   localparam int RAC_CYC    = imax(1, ns_to_cyc(T_RAC_NS, CLK_NS));
   localparam int RASMAX_CYC = T_RASMAX_NS / CLK_NS;
   localparam int MARGIN     = CADDR_CYC + COL_CYC + 3;
   localparam int MAXDUR     = imax(imax(RP_CYC, COL_CYC), imax(RAH_CYC, CADDR_CYC));
   localparam int TMR_W      = $clog2(MAXDUR + 1) + 1;
   localparam int AGE_W      = $clog2(RASMAX_CYC + 2) + 1;

   localparam logic [TMR_W-1:0] RP_V    = TMR_W'(RP_CYC - 1);
   localparam logic [TMR_W-1:0] RAH_V   = TMR_W'(RAH_CYC - 1);
   localparam logic [TMR_W-1:0] CADDR_V = TMR_W'(CADDR_CYC - 1);
   localparam logic [TMR_W-1:0] COL_V   = TMR_W'(COL_CYC - 1);
   localparam logic [AGE_W-1:0] AGE_HOLD = AGE_W'(HOLD_CYC - 1);
   localparam logic [AGE_W-1:0] AGE_RAC  = AGE_W'(RAC_CYC - 1);

   // ---- elaboration checks
   if (ADDR_W != 2 * MA_W) begin : g_bad_addr
      $error("word address must be two memory address widths");
   end
   if (DATA_W != LANES * LANE_W) begin : g_bad_data
      $error("data width must equal lanes times lane width");
   end
   if (RASMAX_CYC <= MARGIN + HOLD_CYC + RAC_CYC) begin : g_bad_rasmax
      $error("row-low limit too small for the clock period");
   end

   // ---- state
   fpm_state_e            state_q, state_d;
   logic [MA_W-1:0]       row_q, col_q;
   logic                  we_q;
   logic [DATA_W-1:0]     wdata_q;
   logic [LANES-1:0]      lane_q;
   logic                  rsp_valid_q;
   logic [DATA_W-1:0]     rdata_q;

   logic                  tmr_load, tmr_zero;
   logic [TMR_W-1:0]      tmr_val;
   logic [AGE_W-1:0]      ras_age;
   logic                  close_due;
   logic                  ras_low, in_col, col_done, page_hit, accept;

   fpm_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   fpm_ras_guard #(.MAX_CYC(RASMAX_CYC), .MARGIN(MARGIN), .W(AGE_W)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_low   (ras_low),
      .age       (ras_age),
      .close_due (close_due)
   );

   assign page_hit = (req_addr[ADDR_W-1:MA_W] == row_q);

   // ---- next state
   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      req_ready = 1'b0;
      col_done  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (ref_req) begin
               state_d = ST_REF;
            end else begin
               req_ready = 1'b1;
               if (req_valid) state_d = ST_ROW;
            end
         end
         ST_ROW: begin
            state_d  = ST_ACT;
            tmr_load = 1'b1;
            tmr_val  = RAH_V;
         end
         ST_ACT: begin
            if (tmr_zero) begin
               state_d  = ST_CADDR;
               tmr_load = 1'b1;
               tmr_val  = CADDR_V;
            end
         end
         ST_CADDR: begin
            if (tmr_zero) begin
               state_d  = ST_COL;
               tmr_load = 1'b1;
               tmr_val  = COL_V;
            end
         end
         ST_COL: begin
            if (tmr_zero && (ras_age >= AGE_RAC)) begin
               col_done = 1'b1;
               state_d  = ST_OPEN;
            end
         end
         ST_OPEN: begin
            if (ref_req || close_due || (req_valid && !page_hit)) begin
               if (ras_age >= AGE_HOLD) begin
                  state_d  = ST_PRE;
                  tmr_load = 1'b1;
                  tmr_val  = RP_V;
               end
            end else begin
               req_ready = 1'b1;
               if (req_valid) begin
                  state_d  = ST_CADDR;
                  tmr_load = 1'b1;
                  tmr_val  = CADDR_V;
               end
            end
         end
         ST_PRE: begin
            if (tmr_zero) state_d = ref_req ? ST_REF : ST_IDLE;
         end
         ST_REF: begin
            if (!ref_req) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign accept = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         row_q       <= '0;
         col_q       <= '0;
         we_q        <= 1'b0;
         wdata_q     <= '0;
         lane_q      <= '0;
         rsp_valid_q <= 1'b0;
         rdata_q     <= '0;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= col_done && !we_q;
         if (col_done && !we_q) rdata_q <= dram_dq_in;
         if (accept) begin
            col_q   <= req_addr[MA_W-1:0];
            we_q    <= req_we;
            wdata_q <= req_wdata;
            lane_q  <= req_lane;
            if (state_q == ST_IDLE) row_q <= req_addr[ADDR_W-1:MA_W];
         end
      end
   end

   // ---- memory pins
   assign ras_low = (state_q == ST_ACT) || (state_q == ST_CADDR) ||
                    (state_q == ST_COL) || (state_q == ST_OPEN);
   assign in_col  = (state_q == ST_COL);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dram_cas_n[i] = !(in_col && (!we_q || lane_q[i]));
   end

   assign dram_ras_n  = !ras_low;
   assign dram_we_n   = !(we_q && ((state_q == ST_CADDR) || in_col));
   assign dram_oe_n   = !(!we_q && in_col);
   assign dram_dq_oe  = we_q && ((state_q == ST_CADDR) || in_col);
   assign dram_dq_out = wdata_q;
   assign dram_addr   = ((state_q == ST_CADDR) || in_col || (state_q == ST_OPEN)) ? col_q : row_q;
   assign ref_gnt     = (state_q == ST_REF);
   assign rsp_valid   = rsp_valid_q;
   assign rsp_rdata   = rdata_q;

   // ---- assertions
   // R1: row address stable across the row strobe fall
   a_r1_row_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> $stable(dram_addr));
   // R1: column address stable across the column strobe fall
   a_r1_col_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(&dram_cas_n) |-> $stable(dram_addr));
   // R2: reads strobe every lane
   a_r2_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (dram_cas_n == '0));
   // R3: write enable precedes the column strobe
   a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(&dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
   // R3: output enable off and data driven while writing
   a_r3_write_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> (dram_oe_n && dram_dq_oe));
   // R8: minimum row-low time before precharge
   a_r8_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> ($past(ras_age) >= AGE_HOLD));
   // R9: grant only with the memory quiet
   a_r9_gnt_closed: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> (dram_ras_n && (&dram_cas_n)));
   // R10: no host acceptance during refresh
   a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_gnt || ref_req) |-> !req_ready);

endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;

   localparam int RP_C       = 2;
   localparam int HOLD_C     = 4;
   localparam int COL_C      = 2;
   localparam int RASMAX_C   = 500;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, req_valid, req_ready, req_we, rsp_valid, ref_req, ref_gnt;
   logic [19:0] req_addr;
   logic [35:0] req_wdata, rsp_rdata, dram_dq_out, dram_dq_in;
   logic [3:0]  req_lane, dram_cas_n;
   logic [9:0]  dram_addr;
   logic        dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;

   fpm_dram_ctrl u_fpm_dram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_lane(req_lane),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
      .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   int n_checks = 0;
   int n_err    = 0;

   task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_ge(input string tag, input int act, input int lo);
      n_checks++;
      if (act < lo) begin
         n_err++;
         $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
      end
   endtask

   task automatic check_le(input string tag, input int act, input int hi);
      n_checks++;
      if (act > hi) begin
         n_err++;
         $display("FAIL %s actual=%0d expected<=%0d", tag, act, hi);
      end
   endtask

   // ---- memory model
   logic [35:0] mem [bit [19:0]];
   logic [9:0]  m_row = '0, m_col = '0;
   logic [3:0]  cas_prev = 4'hF;
   logic [35:0] rd_word;

   function automatic logic [35:0] mget(input logic [19:0] k);
      if (mem.exists(k)) return mem[k];
      return '0;
   endfunction

   always @(negedge dram_ras_n) m_row = dram_addr;

   always @(dram_cas_n) begin : model_cas
      logic [35:0] w;
      for (int i = 0; i < 4; i++) begin
         if (cas_prev[i] && !dram_cas_n[i]) begin
            m_col = dram_addr;
            if (!dram_we_n) begin
               w = mget({m_row, dram_addr});
               w[i*9 +: 9] = dram_dq_out[i*9 +: 9];
               mem[{m_row, dram_addr}] = w;
            end
         end
      end
      cas_prev = dram_cas_n;
   end

   always @(m_row or m_col or dram_oe_n) rd_word = mget({m_row, m_col});
   assign dram_dq_in = (!dram_oe_n && !(&dram_cas_n)) ? rd_word : '0;

   // ---- scoreboard
   logic [35:0] exp_mem [bit [19:0]];
   logic [35:0] sb_q [$];

   function automatic logic [35:0] eget(input logic [19:0] k);
      if (exp_mem.exists(k)) return exp_mem[k];
      return '0;
   endfunction

   task automatic wait_accept();
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send(input logic we, input logic [19:0] a, input logic [35:0] d, input logic [3:0] ln);
      logic [35:0] w;
      @(negedge clk);
      req_valid = 1'b1;
      req_we    = we;
      req_addr  = a;
      req_wdata = d;
      req_lane  = ln;
      wait_accept();
      if (we) begin
         w = eget(a);
         for (int i = 0; i < 4; i++) if (ln[i]) w[i*9 +: 9] = d[i*9 +: 9];
         exp_mem[a] = w;
      end else begin
         sb_q.push_back(eget(a));
      end
   endtask

   task automatic settle();
      repeat (10) @(negedge clk);
   endtask

   // ---- monitors
   int  lo_run = 0, hi_run = 0, cas_run = 0, ras_falls = 0;
   bit  seen_low = 0;
   logic prev_ras = 1'b1, prev_cas_all = 1'b1, prev_we = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (sb_q.size() == 0) check_eq("R7 unexpected response", 1, 0);
            else check_eq("R7 read data", rsp_rdata, sb_q.pop_front());
         end
         if (!dram_ras_n) begin
            if (prev_ras) ras_falls++;
            if (hi_run > 0 && seen_low) check_ge("R5 precharge cycles", hi_run, RP_C);
            hi_run = 0;
            lo_run++;
            seen_low = 1;
         end else begin
            if (lo_run > 0) begin
               check_ge("R8 row-low cycles", lo_run, HOLD_C);
               check_le("R6 row-low cycles", lo_run, RASMAX_C);
            end
            lo_run = 0;
            hi_run++;
         end
         if (!(&dram_cas_n)) begin
            if (prev_cas_all && !dram_we_n) begin
               check_eq("R3 W low before CAS", prev_we, 1'b0);
               check_eq("R3 OE high in write", dram_oe_n, 1'b1);
               check_eq("R3 data driven", dram_dq_oe, 1'b1);
            end
            cas_run++;
         end else begin
            if (cas_run > 0) check_ge("R8 CAS-low cycles", cas_run, COL_C);
            cas_run = 0;
         end
         if (ref_gnt) begin
            check_eq("R9 quiet at grant", {dram_ras_n, dram_cas_n}, 5'h1F);
            check_eq("R10 ready low in refresh", req_ready, 1'b0);
         end
      end
      prev_ras     = dram_ras_n;
      prev_cas_all = &dram_cas_n;
      prev_we      = dram_we_n;
   end

   // ---- finish and watchdog
   bit done = 0;

   task automatic finish_up();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_up();
      end
   end

   // ---- stimulus
   initial begin : main
      int f0;
      logic [19:0] a1, a2;
      rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
      req_wdata = '0; req_lane = '0; ref_req = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R11 ras_n", dram_ras_n, 1'b1);
      check_eq("R11 cas_n", dram_cas_n, 4'hF);
      check_eq("R11 we_n/oe_n", {dram_we_n, dram_oe_n}, 2'b11);
      check_eq("R11 dq_oe", dram_dq_oe, 1'b0);
      check_eq("R11 rsp_valid/ref_gnt", {rsp_valid, ref_gnt}, 2'b00);
      rst_n = 1'b1;
      #1;
      check_eq("R11 ready after reset", req_ready, 1'b1);

      // R1, R7: write then read a full word
      a1 = {10'h005, 10'h003};
      send(1'b1, a1, 36'h9_1234_5678, 4'hF);
      settle();
      check_eq("R1 row latched", m_row, 10'h005);
      check_eq("R1 col latched", m_col, 10'h003);
      send(1'b0, a1, '0, 4'h0);
      settle();

      // R4: page hits in the open row
      f0 = ras_falls;
      send(1'b1, {10'h005, 10'h010}, 36'hA_BCDE_F012, 4'hF);
      send(1'b0, {10'h005, 10'h010}, '0, 4'h0);
      send(1'b0, a1, '0, 4'h0);
      settle();
      check_eq("R4 no new row strobe", ras_falls, f0);
      check_eq("R1 col of last hit", m_col, 10'h003);

      // R2: partial lane writes
      send(1'b1, a1, 36'h1_1111_1111, 4'b0101);
      send(1'b0, a1, '0, 4'h0);
      send(1'b1, {10'h005, 10'h010}, 36'hF_FFFF_FFFF, 4'b1010);
      send(1'b0, {10'h005, 10'h010}, '0, 4'h0);
      send(1'b1, a1, 36'h0_0000_0000, 4'b0000);
      send(1'b0, a1, '0, 4'h0);
      settle();

      // R5: row miss and return
      a2 = {10'h2A5, 10'h3FF};
      f0 = ras_falls;
      send(1'b1, a2, 36'h5_A5A5_A5A5, 4'hF);
      send(1'b0, a1, '0, 4'h0);
      send(1'b0, a2, '0, 4'h0);
      settle();
      check_eq("R5 one row open per miss", ras_falls, f0 + 3);
      check_eq("R1 new row latched", m_row, 10'h2A5);
      check_eq("R1 top col latched", m_col, 10'h3FF);

      // mixed hits in another row
      for (int k = 0; k < 6; k++) begin
         send(1'b1, {10'h100, 10'(k * 37)}, {4'(k), 32'hC0DE_0000 + 32'(k)}, 4'(k + 9));
         send(1'b0, {10'h100, 10'(k * 37)}, '0, 4'h0);
      end
      settle();

      // R6: idle page closes on its own
      send(1'b0, {10'h100, 10'h000}, '0, 4'h0);
      repeat (700) @(negedge clk);
      check_eq("R6 page closed after idle", dram_ras_n, 1'b1);
      send(1'b0, {10'h100, 10'h025}, '0, 4'h0);
      settle();

      // R9, R10: refresh with a row open and a host read waiting
      send(1'b1, {10'h007, 10'h001}, 36'h7_7777_0001, 4'hF);
      @(negedge clk);
      ref_req = 1'b1;
      for (int t = 0; t < 50 && !ref_gnt; t++) @(negedge clk);
      check_eq("R9 grant reached", ref_gnt, 1'b1);
      req_valid = 1'b1; req_we = 1'b0; req_addr = {10'h007, 10'h001};
      for (int t = 0; t < 5; t++) begin
         @(negedge clk);
         #1;
         check_eq("R10 request held off", req_ready, 1'b0);
      end
      ref_req = 1'b0;
      wait_accept();
      sb_q.push_back(eget({10'h007, 10'h001}));
      settle();
      check_eq("R10 grant released", ref_gnt, 1'b0);

      // R10: refresh from idle
      repeat (600) @(negedge clk);
      ref_req = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R9 grant from idle", ref_gnt, 1'b1);
      ref_req = 1'b0;
      send(1'b0, a2, '0, 4'h0);
      settle();

      check_eq("R7 all responses returned", sb_q.size(), 0);
      done = 1;
      finish_up();
   end

endmodule